// File: doc/BRIEF.md
# DRAM Calibration Register Readout Model

This block is a synthesizable behavioural model of the read path of a DDR3-style memory device while it serves reads from a small calibration register. It keeps a mode flag and a two-bit location select. Both are loaded by a mode-register-set command that addresses mode register index 3. While the flag is set, each read command returns a burst built from the selected location rather than from the storage array. Location 0 holds a fixed training pattern. The other three locations are reserved and read back as zeros.

A burst is either eight beats long or chopped to four. The burst mode is sampled together with the read command. An eight-beat burst always walks the pattern bits from 0 to 7. A chopped burst covers either the lower or the upper half of the pattern, and read address bit 2 chooses the half. Each beat places the selected pattern bit on every data lane. When the flag is clear, reads produce a fixed marker word on every beat and the beat count is unchanged, which stands in for array data. A write command issued while the flag is set has no effect other than a one-cycle error pulse.

Top module: `mpr_readout`

## Requirements
- R1: After synchronous reset the flag is clear, the location select is 0, and `dq_valid`, `dq_out` and `wr_err` are all 0.
- R2: A command with `cmd_op`=1 (mode set) and `cmd_mr_sel`=3 loads the flag from `cmd_addr[2]` and the location from `cmd_addr[1:0]`. A mode set with any other `cmd_mr_sel` changes neither of them.
- R3: While the flag is set, beat k of a read from location 0 is bit k of parameter `PAT` (default 8'b1010_1010, giving beats 0,1,0,1,...). That bit is copied onto every lane of `dq_out`.
- R4: A read (`cmd_op`=2) with `burst_chop`=0 starts in the cycle after the command. It gives exactly 8 consecutive valid beats in pattern order 0..7, whatever the value of `cmd_addr`.
- R5: A read with `burst_chop`=1 gives exactly 4 valid beats. They follow order 0..3 when `cmd_addr[2]`=0 and order 4..7 when it is 1. `cmd_addr[1:0]` is ignored.
- R6: A read from reserved locations 1, 2 or 3 while the flag is set gives all-zero data, with the same beat count as a location 0 read.
- R7: While the flag is clear, every beat of a read carries the marker `MARK` (default 8'h5A), with the same beat count rule.
- R8: A write (`cmd_op`=3) while the flag is set raises `wr_err` for exactly the next cycle and starts no burst. A write while the flag is clear leaves `wr_err` low.
- R9: A read command that arrives while a burst is running is ignored. A mode set during a burst updates the register, but the running burst keeps the flag and location it captured at its start.
- R10: `dq_out` is 0 in every cycle where `dq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 mode set, 2 read, 3 write |
| cmd_mr_sel | input | 2 | Mode register index for a mode set |
| cmd_addr | input | 3 | Address bits: mode set payload or read column |
| burst_chop | input | 1 | 1 = four-beat chopped burst, 0 = eight beats |
| dq_out | output | 8 | Beat data, one bit replicated on all lanes |
| dq_valid | output | 1 | High on each burst beat |
| wr_err | output | 1 | One-cycle pulse for a write refused in register mode |

## Verification
The hazard case is a new command landing on the same cycle as a burst beat that is being streamed. The bench starts an eight-beat read and, in the middle of it, issues a second read and then a mode set that moves to a reserved location. It expects the running burst to finish all eight pattern beats unchanged. The read after that must return zeros. The same overlap is used for a refused write during a burst: `wr_err` must pulse while the beats continue. A second instance with an asymmetric pattern turns any mistake in beat order or chopped-half selection into a visible data mismatch across a full sweep of location, burst mode and address.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int FULL_BEATS = 8;
    localparam int BEAT_W     = $clog2(FULL_BEATS);
    localparam int LOC_W      = 2;
    localparam int NUM_LOC    = 1 << LOC_W;
    localparam int ADDR_W     = 3;
    localparam int SEL_W      = 2;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_MRS = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } cmd_op_e;

    typedef struct packed {
        logic             en;
        logic [LOC_W-1:0] loc;
    } mpr_cfg_t;

    function automatic logic [BEAT_W-1:0] first_beat(input logic chop, input logic half_sel);
        logic [BEAT_W-1:0] b;
        b = '0;
        if (chop) b[BEAT_W-1] = half_sel;
        return b;
    endfunction

    function automatic logic [BEAT_W:0] beat_count(input logic chop);
        return chop ? (BEAT_W+1)'(FULL_BEATS/2) : (BEAT_W+1)'(FULL_BEATS);
    endfunction

endpackage

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg
    import mpr_pkg::*;
#(
    parameter int unsigned MR_INDEX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_fire,
    input  logic [SEL_W-1:0]  mr_sel,
    input  logic [ADDR_W-1:0] addr,
    output mpr_cfg_t          cfg
);

    logic hit;
    assign hit = mrs_fire && (mr_sel == SEL_W'(MR_INDEX));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit) begin
            cfg.en  <= addr[2];
            cfg.loc <= addr[LOC_W-1:0];
        end
    end

    // R2: a mode set to the selected index lands in the register
    p_mrs_load_r2: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cfg.en == $past(addr[2])) && (cfg.loc == $past(addr[LOC_W-1:0])));

    // R2: other indices leave the register untouched
    p_mrs_other_r2: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cfg));

endmodule

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              chop,
    input  logic              half_sel,
    input  mpr_cfg_t          cfg_in,
    output logic              active,
    output logic [BEAT_W-1:0] beat,
    output mpr_cfg_t          cfg_lat
);

    logic [BEAT_W:0] left_q;
    logic            start;

    assign start = rd_fire && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            beat    <= '0;
            left_q  <= '0;
            cfg_lat <= '0;
        end else if (start) begin
            active  <= 1'b1;
            beat    <= first_beat(chop, half_sel);
            left_q  <= beat_count(chop);
            cfg_lat <= cfg_in;
        end else if (active) begin
            beat   <= beat + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == (BEAT_W+1)'(1)) active <= 1'b0;
        end
    end

    // R4: beats advance one step per cycle until the count runs out
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (active && left_q > (BEAT_W+1)'(1)) |=> (active && beat == $past(beat) + 1'b1));

    // R4: the burst ends after its last beat
    p_end_r4: assert property (@(posedge clk) disable iff (rst)
        (active && left_q == (BEAT_W+1)'(1)) |=> !active);

    // R5: chopped bursts load half the beat count
    p_chop_len_r5: assert property (@(posedge clk) disable iff (rst)
        (start && chop) |=> (left_q == (BEAT_W+1)'(FULL_BEATS/2)));

    // R9: captured configuration stays put for the whole burst
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (active && left_q > (BEAT_W+1)'(1)) |=> $stable(cfg_lat));

endmodule

// File: rtl/mpr_beat_data.sv
module mpr_beat_data
    import mpr_pkg::*;
#(
    parameter int                     DQ_W = 8,
    parameter logic [FULL_BEATS-1:0]  PAT  = 8'b1010_1010,
    parameter logic [DQ_W-1:0]        MARK = DQ_W'(8'h5A)
) (
    input  logic              active,
    input  logic [BEAT_W-1:0] beat,
    input  mpr_cfg_t          cfg,
    output logic [DQ_W-1:0]   dq
);

    logic [FULL_BEATS-1:0] loc_pat [NUM_LOC];

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        if (g == 0) begin : g_cal
            assign loc_pat[g] = PAT;
        end else begin : g_rsvd
            assign loc_pat[g] = '0;
        end
    end

    logic bit_sel;
    assign bit_sel = loc_pat[cfg.loc][beat];

    always_comb begin
        if (!active)     dq = '0;
        else if (cfg.en) dq = {DQ_W{bit_sel}};
        else             dq = MARK;
    end

endmodule

// File: rtl/mpr_readout.sv
module mpr_readout
    import mpr_pkg::*;
#(
    parameter int                    DQ_W = 8,
    parameter logic [FULL_BEATS-1:0] PAT  = 8'b1010_1010,
    parameter logic [DQ_W-1:0]       MARK = DQ_W'(8'h5A)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SEL_W-1:0]  cmd_mr_sel,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              burst_chop,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_valid,
    output logic              wr_err
);

    cmd_op_e           op;
    mpr_cfg_t          cfg_now;
    mpr_cfg_t          cfg_run;
    logic [BEAT_W-1:0] beat;
    logic              mrs_fire, rd_fire, wr_fire;

    assign op       = cmd_op_e'(cmd_op);
    assign mrs_fire = cmd_valid && (op == OP_MRS);
    assign rd_fire  = cmd_valid && (op == OP_RD);
    assign wr_fire  = cmd_valid && (op == OP_WR);

    mpr_mode_reg #(.MR_INDEX(3)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .mrs_fire(mrs_fire),
        .mr_sel  (cmd_mr_sel),
        .addr    (cmd_addr),
        .cfg     (cfg_now)
    );

    mpr_burst_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rd_fire (rd_fire),
        .chop    (burst_chop),
        .half_sel(cmd_addr[2]),
        .cfg_in  (cfg_now),
        .active  (dq_valid),
        .beat    (beat),
        .cfg_lat (cfg_run)
    );

    mpr_beat_data #(.DQ_W(DQ_W), .PAT(PAT), .MARK(MARK)) u_data (
        .active(dq_valid),
        .beat  (beat),
        .cfg   (cfg_run),
        .dq    (dq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= wr_fire && cfg_now.en;
    end

    // R8: the error pulse only follows a write made in register mode
    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(cmd_valid && cmd_op == 2'd3 && cfg_now.en));

    // R4: an idle read opens a burst on the next cycle
    p_rd_start_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !dq_valid) |=> dq_valid);

    // R10: data lanes are quiet outside a burst
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dq_valid |-> (dq_out == '0));

endmodule

// File: tb/mpr_readout_tb.sv
module mpr_readout_tb_top;

    localparam logic [7:0] PAT_A  = 8'b1010_1010;
    localparam logic [7:0] PAT_B  = 8'b1110_0100;
    localparam logic [7:0] MARK_V = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_mr_sel = 2'd0;
    logic [2:0] cmd_addr = 3'd0;
    logic       burst_chop = 1'b0;
    logic [7:0] dq_a, dq_b;
    logic       vld_a, vld_b, err_a, err_b;

    int n_run = 0;
    int n_fail = 0;

    // model state kept by the bench
    logic       m_en = 1'b0;
    logic [1:0] m_loc = 2'd0;

    always #2 clk = ~clk;

    mpr_readout dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mr_sel(cmd_mr_sel), .cmd_addr(cmd_addr), .burst_chop(burst_chop),
        .dq_out(dq_a), .dq_valid(vld_a), .wr_err(err_a)
    );

    mpr_readout #(.PAT(PAT_B)) dut2_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mr_sel(cmd_mr_sel), .cmd_addr(cmd_addr), .burst_chop(burst_chop),
        .dq_out(dq_b), .dq_valid(vld_b), .wr_err(err_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_beat(input logic [7:0] pat, input int b);
        if (!m_en)         return MARK_V;
        if (m_loc != 2'd0) return 8'h00;
        return {8{pat[b]}};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [1:0] sel, input logic [2:0] a, input logic chop);
        cmd_valid = 1'b1; cmd_op = op; cmd_mr_sel = sel; cmd_addr = a; burst_chop = chop;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic mrs(input logic [1:0] sel, input logic [2:0] a);
        issue(2'd1, sel, a, 1'b0);
        if (sel == 2'd3) begin m_en = a[2]; m_loc = a[1:0]; end
    endtask

    // R4 R5 R6 R7: read and check each beat, then the idle cycle after
    task automatic read_chk(input logic chop, input logic [2:0] a, input string req);
        int n, s;
        n = chop ? 4 : 8;
        s = chop ? (a[2] ? 4 : 0) : 0;
        issue(2'd2, 2'd0, a, chop);
        for (int i = 0; i < n; i++) begin
            chk({req, " valid"}, {7'd0, vld_a & vld_b}, 8'd1);
            chk({req, " data A"}, dq_a, exp_beat(PAT_A, s + i));
            chk({req, " data B"}, dq_b, exp_beat(PAT_B, s + i));
            @(negedge clk);
        end
        chk({req, " end valid"}, {7'd0, vld_a | vld_b}, 8'd0);
        chk("R10 idle data", dq_a | dq_b, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk("R1 valid", {7'd0, vld_a}, 8'd0);
        chk("R1 data", dq_a, 8'd0);
        chk("R1 err", {7'd0, err_a}, 8'd0);
        read_chk(1'b0, 3'd0, "R1 R7 default normal");

        // sweep: location, chop, address (R3 R4 R5 R6)
        for (int l = 0; l < 4; l++) begin
            mrs(2'd3, {1'b1, 2'(l)});
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 8; a++)
                    read_chk(1'(c), 3'(a), c ? "R5 R3 R6 chop" : "R4 R3 R6 bl8");
        end

        // R2: other index has no effect
        mrs(2'd3, 3'b100);
        mrs(2'd2, 3'b011);
        mrs(2'd0, 3'b000);
        read_chk(1'b0, 3'd5, "R2 other index");

        // R8: refused write in register mode
        issue(2'd3, 2'd0, 3'd0, 1'b0);
        chk("R8 err pulse", {6'd0, err_a, err_b}, 8'd3);
        chk("R8 no burst", {7'd0, vld_a}, 8'd0);
        @(negedge clk);
        chk("R8 err single", {7'd0, err_a}, 8'd0);

        // R9: read and mode set while a burst streams; write during burst
        issue(2'd2, 2'd0, 3'd0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R9 burst data", dq_b, {8{PAT_B[i]}});
            chk("R9 burst valid", {7'd0, vld_b}, 8'd1);
            if (i == 1) begin
                issue(2'd2, 2'd0, 3'd4, 1'b1);
            end else if (i == 3) begin
                issue(2'd1, 2'd3, 3'b101, 1'b0);
            end else if (i == 5) begin
                issue(2'd3, 2'd0, 3'd0, 1'b0);
                chk("R8 err during burst", {7'd0, err_a}, 8'd1);
            end else begin
                @(negedge clk);
            end
        end
        chk("R9 burst ends", {7'd0, vld_a}, 8'd0);
        m_en = 1'b1; m_loc = 2'd1;
        read_chk(1'b0, 3'd0, "R9 R6 new location");

        // R7 R8: back to normal
        mrs(2'd3, 3'b000);
        issue(2'd3, 2'd0, 3'd0, 1'b0);
        chk("R8 normal write", {7'd0, err_a}, 8'd0);
        read_chk(1'b1, 3'd4, "R7 normal chop");
        read_chk(1'b0, 3'd7, "R7 normal bl8");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule